// File: doc/BRIEF.md
# Divisible One-Shot / Periodic Countdown Timer

This block is the countdown timer of an interrupt controller. Software programs it through three write-only registers, selected by a two-bit code: a divide setting, an initial count and a control word. A prescaler slows the system clock by a power of two chosen by the divide setting. The count register steps down by one on each prescaled tick. When it expires, the block raises a one-cycle interrupt request that carries an 8-bit vector.

In one-shot mode the count stops at zero and the timer fires once. In periodic mode the count wraps back to the initial value, so each period spans the initial count plus one ticks. The current count is always visible on a read port. Loading the initial count restarts the countdown at once. Rewriting the control word changes the mode, mask or vector but does not touch the running count.

Top module: `cdown_timer`

## Requirements
- R1: After reset the current count is 0 and no request is raised. The control word resets to masked, one-shot, vector 0x00 (value 0x0001_0000). The divide setting resets to divide-by-2 and the initial count to 0.
- R2: A divide write (wrSel=0) keeps only data bits 0, 1 and 3. The code is {bit3, bit1, bit0}, and the count steps once every 2^((code+1) mod 8) clocks. So 0xB gives divide-by-1, 0x0 divide-by-2, 0x2 divide-by-8 and 0x3 divide-by-16. Data bit 2 has no effect: 0x4 behaves as 0x0.
- R3: An initial-count write (wrSel=1) sets the current count to the written value on that clock edge and restarts the prescaler. The first decrement follows 2^shift clocks later.
- R4: In one-shot mode (control bit 17 = 0) the count falls to 0 and holds there. Exactly one expiry occurs, on the tick after the count reaches 0, which is initial+1 ticks after the load. A load of 0 produces no expiry.
- R5: In periodic mode (control bit 17 = 1) with a nonzero initial value, the tick that finds the count at 0 reloads the initial value and produces an expiry. Each period is therefore initial+1 ticks.
- R6: In periodic mode with an initial count of 0, the count stays 0 and no expiry is produced.
- R7: While control bit 16 is set, expiries raise no request, but the count keeps running and reloading. A one-shot expiry that occurs while masked is used up.
- R8: A control-word write (wrSel=2) leaves the current count unchanged.
- R9: Each expiry raises irqReq for exactly one cycle, starting one clock after the edge on which the count expired. irqVector then holds control bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select: 0 divide, 1 initial count, 2 control, 3 none |
| wrData | input | 32 | Write data |
| curCount | output | 32 | Current count |
| irqReq | output | 1 | One-cycle interrupt request |
| irqVector | output | 8 | Vector that goes with irqReq |

## Verification
Directed loads at divide-by-1, 2, 8 and 16 check the tick rate and show whether the divide code is decoded from the correct scattered bits. A write of 0x4 can only match the expected rate if bit 2 is dropped. Short one-shot and periodic loads are checked by counting request pulses in a fixed window. This separates a single firing from repeated firing and confirms the initial+1 period. It also shows that a zero periodic load and a masked timer stay silent. A random mix of writes, including loads, mode and mask changes and divide changes in the middle of a countdown, is compared cycle by cycle against a reference model in the bench. This exposes timing slips at the edges between the prescaler, a load and an expiry.

// File: rtl/cdown_pkg.sv
package cdown_pkg;
  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_DIV  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_INIT = 2'd1;
  localparam logic [SEL_W-1:0] SEL_CTRL = 2'd2;
  localparam int BIT_PERIODIC = 17;
  localparam int BIT_MASK     = 16;
  localparam int CODE_W       = 3;
  localparam int PRE_W        = 2 ** CODE_W;

  typedef struct packed {
    logic load;
    logic tick;
    logic periodic;
  } tmrCmd_t;
endpackage

// File: rtl/cdown_ctrl.sv
module cdown_ctrl
  import cdown_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [DATA_W-1:0] wrData,
  output tmrCmd_t           cmd,
  output logic [DATA_W-1:0] initVal,
  output logic              maskBit,
  output logic [VEC_W-1:0]  vector
);
  localparam logic [DATA_W-1:0] CTRL_RST = DATA_W'(1) << BIT_MASK;

  logic [3:0]        divCfg;
  logic [DATA_W-1:0] ctrlWord;
  logic [PRE_W-1:0]  preCnt;
  logic [CODE_W-1:0] divCode;
  logic [CODE_W-1:0] shiftAmt;
  logic [PRE_W-1:0]  divM1;
  logic              loadNow;
  logic              tickNow;

  // scattered divide code: bit 3 acts as code bit 2
  assign divCode  = {divCfg[3], divCfg[1:0]};
  assign shiftAmt = divCode + CODE_W'(1);
  assign divM1    = (PRE_W'(1) << shiftAmt) - PRE_W'(1);

  assign loadNow = wrEn && (wrSel == SEL_INIT);
  assign tickNow = !loadNow && (preCnt >= divM1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divCfg   <= 4'h0;
      ctrlWord <= CTRL_RST;
      initVal  <= '0;
    end else if (wrEn) begin
      case (wrSel)
        SEL_DIV:  divCfg   <= wrData[3:0] & 4'hB;
        SEL_INIT: initVal  <= wrData;
        SEL_CTRL: ctrlWord <= wrData;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 preCnt <= '0;
    else if (loadNow || tickNow) preCnt <= '0;
    else                         preCnt <= preCnt + PRE_W'(1);
  end

  assign cmd.load     = loadNow;
  assign cmd.tick     = tickNow;
  assign cmd.periodic = ctrlWord[BIT_PERIODIC];
  assign maskBit      = ctrlWord[BIT_MASK];
  assign vector       = ctrlWord[VEC_W-1:0];
endmodule

// File: rtl/cdown_dp.sv
module cdown_dp
  import cdown_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmrCmd_t           cmd,
  input  logic [DATA_W-1:0] initVal,
  input  logic [DATA_W-1:0] loadVal,
  output logic [DATA_W-1:0] count,
  output logic              expEvt
);
  logic armed;
  logic atZero;
  logic fire;

  assign atZero = (count == '0);
  assign fire   = cmd.tick && atZero &&
                  (cmd.periodic ? (initVal != '0) : armed);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      armed  <= 1'b0;
      expEvt <= 1'b0;
    end else if (cmd.load) begin
      count  <= loadVal;
      armed  <= (loadVal != '0);
      expEvt <= 1'b0;
    end else begin
      expEvt <= fire;
      if (fire && cmd.periodic)         count <= initVal;
      else if (cmd.tick && !atZero)     count <= count - DATA_W'(1);
      if (fire && !cmd.periodic)        armed <= 1'b0;
    end
  end
endmodule

// File: rtl/cdown_timer.sv
module cdown_timer
  import cdown_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] curCount,
  output logic              irqReq,
  output logic [VEC_W-1:0]  irqVector
);
  tmrCmd_t           cmd;
  logic [DATA_W-1:0] initVal;
  logic              maskBit;
  logic [VEC_W-1:0]  vector;
  logic              expEvt;

  cdown_ctrl #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .cmd(cmd), .initVal(initVal), .maskBit(maskBit), .vector(vector)
  );

  cdown_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .initVal(initVal),
    .loadVal(wrData), .count(curCount), .expEvt(expEvt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irqReq    <= 1'b0;
      irqVector <= '0;
    end else begin
      irqReq    <= expEvt && !maskBit;
      irqVector <= vector;
    end
  end
endmodule

// File: rtl/cdown_timer_chk.sv
module cdown_timer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wrEn,
  input logic [1:0]        wrSel,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] curCount,
  input logic              irqReq,
  input logic              periodic,
  input logic              masked
);
  logic loadW;
  assign loadW = wrEn && (wrSel == 2'd1);

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    loadW |=> curCount == $past(wrData)); // R3

  AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!periodic && curCount == '0 && !loadW) |=> curCount == '0); // R4

  AST_STEP_OR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!loadW && curCount != '0) |=>
      (curCount == $past(curCount) || curCount == $past(curCount) - DATA_W'(1))); // R5

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    masked |=> !irqReq); // R7

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |=> !irqReq); // R9
endmodule

bind cdown_timer cdown_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
  .curCount(curCount), .irqReq(irqReq), .periodic(cmd.periodic), .masked(maskBit)
);

// File: tb/tb_cdown_timer.sv
module tb_cdown_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd3;
  logic [31:0] wrData = '0;
  logic [31:0] curCount;
  logic        irqReq;
  logic [7:0]  irqVector;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  cdown_timer dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .curCount(curCount), .irqReq(irqReq), .irqVector(irqVector)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int unsigned divOf(input logic [3:0] c);
    logic [2:0] code;
    code = {c[3], c[1:0]};
    return 32'd1 << ((code + 3'd1) % 8);
  endfunction

  // reference model from the requirements
  int unsigned mPre;
  logic [31:0] mCount, mInit, mCtrl;
  logic [3:0]  mDiv;
  logic        mArmed, mEvt, mIrq;
  logic [7:0]  mVec;

  always @(posedge clk) begin
    int unsigned dv;
    logic tk, fire;
    if (!rst_n) begin
      mPre = 0; mCount = 0; mInit = 0; mCtrl = 32'h0001_0000; mDiv = 0;
      mArmed = 0; mEvt = 0; mIrq = 0; mVec = 0;
    end else begin
      dv = divOf(mDiv);
      mIrq = mEvt && !mCtrl[16];
      mVec = mCtrl[7:0];
      if (wrEn && wrSel == 2'd1) begin
        mCount = wrData; mPre = 0; mArmed = (wrData != 0); mEvt = 0;
      end else begin
        tk = (mPre >= dv - 1);
        mPre = tk ? 0 : mPre + 1;
        fire = tk && (mCount == 0) && (mCtrl[17] ? (mInit != 0) : mArmed);
        mEvt = fire;
        if (fire && mCtrl[17]) mCount = mInit;
        else if (tk && mCount != 0) mCount = mCount - 1;
        if (fire && !mCtrl[17]) mArmed = 0;
      end
      if (wrEn) begin
        case (wrSel)
          2'd0: mDiv = wrData[3:0] & 4'hB;
          2'd1: mInit = wrData;
          2'd2: mCtrl = wrData;
          default: ;
        endcase
      end
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 count vs model", curCount, mCount);
      chk("R9 request vs model", irqReq, mIrq);
      if (irqReq && mIrq) chk("R9 vector vs model", irqVector, mVec);
    end
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    wrEn = 1'b1; wrSel = s; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrSel = 2'd3;
  endtask

  task automatic quiet();
    wr(2'd2, 32'h0001_0000);
    wr(2'd1, 32'd0);
    repeat (3) @(negedge clk);
  endtask

  task automatic countPulses(input int n, output int pulses, output int firstAt);
    pulses = 0; firstAt = -1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (irqReq) begin
        if (firstAt < 0) firstAt = i;
        pulses++;
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p, f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset count", curCount, 0);
    chk("R1 reset request", irqReq, 0);
    // reset divide is by 2; reset control is masked
    wr(2'd1, 32'd5);
    repeat (2) @(negedge clk);
    chk("R1 reset divide by 2", curCount, 4);
    countPulses(20, p, f);
    chk("R1 reset masked", p, 0);

    // one-shot, divide by 1
    quiet();
    wr(2'd0, 32'hB);
    wr(2'd2, 32'h0000_0040);
    wr(2'd1, 32'd3);
    chk("R3 load value", curCount, 3);
    repeat (3) @(negedge clk);
    chk("R4 reaches zero", curCount, 0);
    countPulses(20, p, f);
    chk("R4 single expiry", p, 1);
    chk("R9 request one clock after expiry", f, 2);
    chk("R4 holds zero", curCount, 0);

    // divide decode
    quiet();
    wr(2'd0, 32'h0);
    wr(2'd1, 32'd4);
    repeat (2) @(negedge clk);
    chk("R2 div2 after 2", curCount, 3);
    @(negedge clk);
    chk("R2 div2 after 3", curCount, 3);
    wr(2'd0, 32'h4);
    wr(2'd1, 32'd10);
    repeat (2) @(negedge clk);
    chk("R2 bit2 ignored", curCount, 9);
    wr(2'd0, 32'h2);
    wr(2'd1, 32'd10);
    repeat (7) @(negedge clk);
    chk("R2 div8 before", curCount, 10);
    @(negedge clk);
    chk("R2 div8 step", curCount, 9);

    // periodic initial 2 at divide by 1
    quiet();
    wr(2'd0, 32'hB);
    wr(2'd2, 32'h0002_0055);
    wr(2'd1, 32'd2);
    countPulses(30, p, f);
    chk("R5 periodic pulses", p, 9);
    chk("R5 first period", f, 4);

    // periodic initial 0
    quiet();
    wr(2'd2, 32'h0002_0012);
    wr(2'd1, 32'd0);
    countPulses(20, p, f);
    chk("R6 zero periodic silent", p, 0);
    chk("R6 count stays", curCount, 0);

    // masked periodic
    quiet();
    wr(2'd2, 32'h0003_0007);
    wr(2'd1, 32'd1);
    @(negedge clk);
    chk("R7 masked count runs", curCount, 0);
    countPulses(20, p, f);
    chk("R7 masked silent", p, 0);

    // control rewrite keeps count
    quiet();
    wr(2'd0, 32'h3);
    wr(2'd1, 32'd9);
    repeat (3) @(negedge clk);
    wr(2'd2, 32'h0002_0000);
    chk("R8 count unchanged", curCount, 9);
    wr(2'd2, 32'h0000_0033);
    chk("R8 count unchanged again", curCount, 9);

    // random mix checked against the model
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 11) == 0) begin
        case ($urandom_range(0, 3))
          0: wr(2'd0, 32'($urandom_range(0, 15)));
          1: wr(2'd1, 32'($urandom_range(0, 12)));
          2: wr(2'd2, {14'd0, 1'($urandom_range(0, 1)),
                       ($urandom_range(0, 3) == 0), 8'd0, 8'($urandom)});
          default: wr(2'd3, $urandom);
        endcase
      end else begin
        @(negedge clk);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule